// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is the integer execute stage for a simple datapath. It takes two operands and a three-bit operation code. It returns a result word, a carry flag and an overflow flag, computed by a chain of identical one-bit slices. Each slice holds three pieces: a bitwise AND/OR stage, a full adder, and a multiplexer that picks the value the slice drives. The carry ripples from the lowest slice to the highest.

Subtraction uses the same adder. Each B bit is inverted through an XOR and the lowest slice gets a carry-in of one, so the adder computes A + ~B + 1. Any sign or zero extension of immediates is done upstream, so both operand ports are always full words.

The result and both flags are captured in a register on the rising clock edge. The block therefore has a latency of one cycle and accepts a new operation every cycle.

Top module: `bslice_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `carry_o` and `ovf_o` become 0 after that edge.
- R2: Code 000 gives A AND B and code 001 gives A OR B, bit by bit.
- R3: Codes 010 (signed add) and 011 (unsigned add) give (A + B) mod 2^32. `carry_o` is the carry out of bit 31.
- R4: Codes 100 (signed subtract) and 101 (unsigned subtract) give (A - B) mod 2^32, formed as A + ~B + 1. `carry_o` is the carry out of bit 31, so it is 1 exactly when A >= B as unsigned numbers.
- R5: For codes 010 and 100, `ovf_o` is the carry into bit 31 XOR the carry out of bit 31. This equals two's-complement overflow of the signed result.
- R6: `ovf_o` is 0 for codes 000, 001, 011 and 101.
- R7: `carry_o` is 0 for the logic codes 000 and 001.
- R8: Codes 110 and 111 give a zero result, with `carry_o` and `ovf_o` both 0.
- R9: Outputs show the operands and code sampled at the previous rising edge. They hold steady between edges even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_sel | input | 3 | Operation code |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered carry out of bit 31 (arithmetic only) |
| ovf_o | output | 1 | Registered signed overflow (signed add/subtract only) |

## Verification
The signed boundary cases probe the overflow rule:
- 0x7FFFFFFF + 1 and 0x80000000 - 1 overflow.
- 0 - 0 does not overflow, but it produces a carry.
- Running the same operands under the signed and unsigned codes confirms that overflow is masked for the unsigned codes only.

An operand pair of all ones plus one makes the carry ripple through every slice. This shows whether any link in the chain is broken.

Random operands under every code are compared with a word-level reference model. The reserved codes are applied after operations that leave non-zero outputs, so a stale value would show up.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_ADDU = 3'b011,
    OP_SUB  = 3'b100,
    OP_SUBU = 3'b101
  } op_e;

  typedef enum logic [1:0] {
    SRC_AND  = 2'd0,
    SRC_OR   = 2'd1,
    SRC_SUM  = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] op_i,
  output logic       b_inv_o,
  output logic       cin0_o,
  output src_e       src_o,
  output logic       arith_o,
  output logic       signed_o
);
  always_comb begin
    b_inv_o  = 1'b0;
    cin0_o   = 1'b0;
    src_o    = SRC_ZERO;
    arith_o  = 1'b0;
    signed_o = 1'b0;
    case (op_i)
      OP_AND:  src_o = SRC_AND;
      OP_OR:   src_o = SRC_OR;
      OP_ADD:  begin src_o = SRC_SUM; arith_o = 1'b1; signed_o = 1'b1; end
      OP_ADDU: begin src_o = SRC_SUM; arith_o = 1'b1; end
      OP_SUB:  begin src_o = SRC_SUM; arith_o = 1'b1; signed_o = 1'b1;
                     b_inv_o = 1'b1; cin0_o = 1'b1; end
      OP_SUBU: begin src_o = SRC_SUM; arith_o = 1'b1;
                     b_inv_o = 1'b1; cin0_o = 1'b1; end
      default: src_o = SRC_ZERO;
    endcase
  end

  always_comb begin
    assert (!(signed_o && !arith_o));           // R5
    assert (!(b_inv_o && src_o != SRC_SUM));    // R4
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  logic b_inv_i,
  input  src_e src_i,
  output logic res_o,
  output logic cout_o
);
  logic b_eff;
  logic sum;

  assign b_eff  = b_i ^ b_inv_i;
  assign sum    = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & cin_i) | (b_eff & cin_i) | (a_i & b_eff);

  always_comb begin
    case (src_i)
      SRC_AND: res_o = a_i & b_i;
      SRC_OR:  res_o = a_i | b_i;
      SRC_SUM: res_o = sum;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic             b_inv, cin0, arith, is_signed;
  src_e             src;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] res_w;
  logic             carry_w, ovf_w;

  alu_ctrl u_ctrl (
    .op_i     (op_sel),
    .b_inv_o  (b_inv),
    .cin0_o   (cin0),
    .src_o    (src),
    .arith_o  (arith),
    .signed_o (is_signed)
  );

  assign chain[0] = cin0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i     (op_a[i]),
      .b_i     (op_b[i]),
      .cin_i   (chain[i]),
      .b_inv_i (b_inv),
      .src_i   (src),
      .res_o   (res_w[i]),
      .cout_o  (chain[i+1])
    );
  end

  assign carry_w = arith & chain[WIDTH];
  assign ovf_w   = is_signed & (chain[MSB] ^ chain[WIDTH]);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_w;
      carry_o  <= carry_w;
      ovf_o    <= ovf_w;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !carry_o && !ovf_o)); // R1
  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_AND) |=> result_o == ($past(op_a) & $past(op_b))); // R2
  AST_OR_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_OR) |=> result_o == ($past(op_a) | $past(op_b))); // R2
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD || op_sel == OP_ADDU)
      |=> result_o == $past(op_a) + $past(op_b)); // R3
  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SUB || op_sel == OP_SUBU)
      |=> result_o == $past(op_a) - $past(op_b)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(op_sel == OP_ADD || op_sel == OP_SUB) |=> !ovf_o); // R6
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_AND || op_sel == OP_OR) |=> !carry_o); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] == 2'b11) |=> (result_o == '0 && !carry_o && !ovf_o)); // R8
endmodule

// File: tb/bslice_alu_test.sv
module bslice_alu_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b;
  logic [2:0]  op_sel;
  logic [31:0] result_o;
  logic        carry_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bslice_alu #(.WIDTH(32)) uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] op, output logic [31:0] r,
                       output logic c, output logic v);
    logic [32:0] w;
    r = '0; c = 1'b0; v = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010, 3'b011: begin
        w = {1'b0, a} + {1'b0, b};
        r = w[31:0]; c = w[32];
        if (op == 3'b010) v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'b100, 3'b101: begin
        w = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = w[31:0]; c = w[32];
        if (op == 3'b100) v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      default: ;
    endcase
  endtask

  task automatic compare(input string req, input logic [31:0] er,
                         input logic ec, input logic ev);
    checks++;
    if (result_o !== er || carry_o !== ec || ovf_o !== ev) begin
      errors++;
      $display("FAIL %s: got r=%h c=%b v=%b expected r=%h c=%b v=%b",
               req, result_o, carry_o, ovf_o, er, ec, ev);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] a,
                        input logic [31:0] b, input logic [2:0] op);
    logic [31:0] er; logic ec, ev;
    model(a, b, op, er, ec, ev);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op;
    @(negedge clk);
    compare(req, er, ec, ev);
  endtask

  task automatic test_reset();
    @(negedge clk);
    op_a = 32'h7FFFFFFF; op_b = 32'h1; op_sel = 3'b010; rst = 1'b1;
    @(negedge clk);
    compare("R1", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic test_logic();
    run_op("R2", 32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b000);
    run_op("R2", 32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b001);
    run_op("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000);
    run_op("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b001);
  endtask

  task automatic test_add();
    run_op("R3", 32'hFFFF_FFFF, 32'h1, 3'b011);
    run_op("R3", 32'h1234_5678, 32'h0FED_CBA9, 3'b010);
    run_op("R5", 32'h7FFF_FFFF, 32'h1, 3'b010);
    run_op("R6", 32'h7FFF_FFFF, 32'h1, 3'b011);
    run_op("R5", 32'h8000_0000, 32'h8000_0000, 3'b010);
  endtask

  task automatic test_sub();
    run_op("R4", 32'h0, 32'h0, 3'b100);
    run_op("R4", 32'h0, 32'h1, 3'b101);
    run_op("R5", 32'h8000_0000, 32'h1, 3'b100);
    run_op("R6", 32'h8000_0000, 32'h1, 3'b101);
    run_op("R4", 32'h5, 32'h5, 3'b101);
    run_op("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b100);
  endtask

  task automatic test_reserved();
    run_op("R4", 32'h0, 32'h1, 3'b100);
    run_op("R8", 32'hFFFF_FFFF, 32'h1, 3'b110);
    run_op("R5", 32'h7FFF_FFFF, 32'h1, 3'b010);
    run_op("R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111);
  endtask

  task automatic test_hold();
    logic [31:0] er; logic ec, ev;
    run_op("R9", 32'h7FFF_FFFF, 32'h1, 3'b010);
    model(32'h7FFF_FFFF, 32'h1, 3'b010, er, ec, ev);
    op_a = 32'h0; op_b = 32'h0; op_sel = 3'b110;
    #1;
    compare("R9", er, ec, ev);
    @(negedge clk);
    compare("R9", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      run_op(i % 2 ? "R3" : "R4", $urandom, $urandom, 3'($urandom_range(0, 7)));
    end
  endtask

  initial begin
    rst = 1'b1; op_a = '0; op_b = '0; op_sel = '0;
    repeat (2) @(negedge clk);
    test_reset();
    test_logic();
    test_add();
    test_sub();
    test_reserved();
    test_hold();
    test_random();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule